// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with a small synchronous register bus of 16-bit words. Software turns it on and picks a timeout in units of a base period. The base period is marked by a `tick` input that pulses once per period. It nominally stands for half a second, but a bench can run it with a much shorter period. Once the watchdog is on, software must keep it alive. It does so by writing a two-word key pair to the service register: first 0x5555, then 0xAAAA. Each correct pair reloads a down-counter.

If the counter runs out while the watchdog is on, the block sends a one-cycle reset request to the reset controller. If software asked for it, the block also raises a held timeout output. The block remembers the cause across the next system reset, so software can read why the system restarted. Suspend bits let the count pause while the chip is in debug, low-power or wait mode. The matching mode levels come in as inputs.

The block has two resets. `por_n` is the asynchronous power-on reset and clears everything. `sys_rst_n` is a synchronous system reset. It clears the timer but moves the recorded cause into the status register.

Top module: `wdk_top`

## Requirements
- R1: Registers are addressed by `bus_addr[2:1]`: 0 is control, 1 is service, 2 is status and 3 is unused. Control keeps bits 0 (low-power suspend), 1 (debug suspend), 2 (enable), 3 (timeout-output enable), 7 (wait suspend) and 15:8 (timeout field WT). Its other bits read 0. Service and the unused slot read 0. After reset, control reads 0x0000.
- R2: Once the enable bit (control bit 2) is set, a control write cannot clear it. Only `por_n` or `sys_rst_n` clears it.
- R3: While enabled and not frozen, with no service, `rst_req` goes high after the (WT+1)th tick following the last reload. It goes high in the cycle right after the edge that samples that tick, and not after any earlier tick.
- R4: Writing 0x5555 to service, immediately followed by a service write of 0xAAAA, reloads the counter to WT+1 periods.
- R5: A 0xAAAA service write that does not directly follow a 0x5555 service write does not reload. Any service write other than 0x5555 or 0xAAAA disarms the key sequence.
- R6: `rst_req` is a one-cycle pulse. On expiry the counter reloads to WT+1 and keeps counting, so it expires again after another WT+1 ticks.
- R7: On expiry, `wdt_out` goes high if control bit 3 is set, and stays high until a reset. If bit 3 is clear, `wdt_out` stays low.
- R8: Ticks are ignored while (bit 1 and `dbg_mode`), (bit 0 and `lp_mode`) or (bit 7 and `wait_mode`) is true. A mode input whose suspend bit is clear has no effect.
- R9: The status register is read-only. After power-on it reads 0x0001. After a system reset it reads 0x0002 if the watchdog expired since the previous reset, and 0x0001 otherwise.
- R10: While disabled, ticks never produce `rst_req`.
- R11: Setting the enable bit loads the counter with WT+1 periods, using the WT value written in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Synchronous system reset, active low; captures the cause |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset; bits 2:1 select the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| tick | input | 1 | One-cycle pulse per base period |
| dbg_mode | input | 1 | Chip is in debug mode |
| lp_mode | input | 1 | Chip is in low-power mode |
| wait_mode | input | 1 | Chip is in wait mode |
| rst_req | output | 1 | One-cycle system reset request |
| wdt_out | output | 1 | Held timeout output |

## Verification
Suppose the down-counter holds a wrong value, either after a reload or after a frozen tick. Then `rst_req` appears on the wrong tick. The bench catches this within the WT+1 ticks of that round, because it counts every tick and checks the tick on which the pulse lands. A wrong armed state in the key sequence shows up the same way, as a pulse that comes a full reload period early or late. A lost expiry flag shows up as soon as software reads the status register after the next system reset.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;
    localparam int DATA_W = 16;
    localparam int WT_W   = 8;

    localparam int B_LP   = 0;
    localparam int B_DBG  = 1;
    localparam int B_EN   = 2;
    localparam int B_TOE  = 3;
    localparam int B_WAIT = 7;
    localparam int B_WT   = 8;

    localparam logic [DATA_W-1:0] KEY_ARM  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_SVC  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [WT_W-1:0] wt;
        logic            wait_susp;
        logic            toe;
        logic            en;
        logic            dbg_susp;
        logic            lp_susp;
    } ctl_t;
endpackage

// File: rtl/wdk_regs.sv
`timescale 1ns/1ps
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          srst_n,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    input  logic          expire_i,
    output ctl_t          ctl_o,
    output ctl_t          ctl_nxt_o,
    output logic          en_rise_o,
    output logic [1:0]    stat_o
);
    typedef struct packed {
        ctl_t       ctl;
        logic       fired;
        logic [1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctl) begin
            st_d.ctl.lp_susp   = wdata[B_LP];
            st_d.ctl.dbg_susp  = wdata[B_DBG];
            st_d.ctl.en        = st_q.ctl.en | wdata[B_EN];
            st_d.ctl.toe       = wdata[B_TOE];
            st_d.ctl.wait_susp = wdata[B_WAIT];
            st_d.ctl.wt        = wdata[B_WT +: WT_W];
        end
        if (expire_i) st_d.fired = 1'b1;
        if (!srst_n) begin
            st_d.ctl   = '0;
            st_d.fired = 1'b0;
            st_d.stat  = {st_q.fired, ~st_q.fired};
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.ctl   <= '0;
            st_q.fired <= 1'b0;
            st_q.stat  <= 2'b01;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o     = st_q.ctl;
    assign ctl_nxt_o = st_d.ctl;
    assign en_rise_o = st_d.ctl.en & ~st_q.ctl.en;
    assign stat_o    = st_q.stat;

    // R2: enable stays set until a reset
    p_sticky_en_r2: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.ctl.en && srst_n) |=> st_q.ctl.en);

    // R9: status only changes on a system reset
    p_stat_ro_r9: assert property (@(posedge clk) disable iff (!por_n)
        srst_n |=> $stable(st_q.stat));
endmodule

// File: rtl/wdk_unlock.sv
`timescale 1ns/1ps
module wdk_unlock
    import wdk_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          srst_n,
    input  logic          wr_svc,
    input  logic [DW-1:0] wdata,
    output logic          kick_o
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        kick_o  = 1'b0;
        if (wr_svc) begin
            if (wdata == KEY_ARM) begin
                armed_d = 1'b1;
            end else if (wdata == KEY_FIRE && armed_q) begin
                kick_o  = 1'b1;
                armed_d = 1'b0;
            end else begin
                armed_d = 1'b0;
            end
        end
        if (!srst_n) begin
            armed_d = 1'b0;
            kick_o  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/wdk_counter.sv
`timescale 1ns/1ps
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int WTW = WT_W
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           srst_n,
    input  logic           en,
    input  logic           freeze,
    input  logic           tick,
    input  logic           load,
    input  logic [WTW-1:0] wt,
    input  logic           toe,
    output logic           expire_o,
    output logic           rst_req_o,
    output logic           wdt_out_o
);
    localparam int CNT_W = WTW + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
        logic             wdt;
    } cs_t;

    cs_t cs_d, cs_q;
    logic [CNT_W-1:0] reload_val;

    assign reload_val = CNT_W'(wt) + CNT_W'(1);

    always_comb begin
        cs_d     = cs_q;
        cs_d.req = 1'b0;
        expire_o = 1'b0;
        if (load) begin
            cs_d.cnt = reload_val;
        end else if (en && tick && !freeze) begin
            if (cs_q.cnt <= CNT_W'(1)) begin
                expire_o = 1'b1;
                cs_d.cnt = reload_val;
                cs_d.req = 1'b1;
                if (toe) cs_d.wdt = 1'b1;
            end else begin
                cs_d.cnt = cs_q.cnt - CNT_W'(1);
            end
        end
        if (!srst_n) begin
            cs_d     = '0;
            expire_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign rst_req_o = cs_q.req;
    assign wdt_out_o = cs_q.wdt;

    // R4 / R11: a reload lands the count at WT+1
    p_reload_r4: assert property (@(posedge clk) disable iff (!por_n)
        (load && srst_n) |=> cs_q.cnt == $past(reload_val));

    // R8: a frozen counter holds
    p_freeze_r8: assert property (@(posedge clk) disable iff (!por_n)
        (srst_n && en && freeze && !load) |=> $stable(cs_q.cnt));

    // R10: no request while disabled
    p_no_req_off_r10: assert property (@(posedge clk) disable iff (!por_n)
        !en |=> !cs_q.req);

    // R7: timeout output holds until reset
    p_wdt_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
        (cs_q.wdt && srst_n) |=> cs_q.wdt);
endmodule

// File: rtl/wdk_top.sv
`timescale 1ns/1ps
module wdk_top
    import wdk_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int WTW = WT_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          sys_rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick,
    input  logic          dbg_mode,
    input  logic          lp_mode,
    input  logic          wait_mode,
    output logic          rst_req,
    output logic          wdt_out
);
    reg_sel_e   sel;
    logic       wr_ctl, wr_svc, kick, en_rise, expire, freeze, load;
    ctl_t       ctl, ctl_nxt;
    logic [1:0] stat;

    assign sel    = reg_sel_e'(bus_addr[2:1]);
    assign wr_ctl = bus_sel & bus_wr & (sel == SEL_CTL);
    assign wr_svc = bus_sel & bus_wr & (sel == SEL_SVC);

    wdk_regs #(.DW(DW)) u_regs (
        .clk(clk), .por_n(por_n), .srst_n(sys_rst_n),
        .wr_ctl(wr_ctl), .wdata(bus_wdata), .expire_i(expire),
        .ctl_o(ctl), .ctl_nxt_o(ctl_nxt), .en_rise_o(en_rise), .stat_o(stat)
    );

    wdk_unlock #(.DW(DW)) u_unlock (
        .clk(clk), .por_n(por_n), .srst_n(sys_rst_n),
        .wr_svc(wr_svc), .wdata(bus_wdata), .kick_o(kick)
    );

    assign freeze = (ctl.dbg_susp  & dbg_mode) |
                    (ctl.lp_susp   & lp_mode)  |
                    (ctl.wait_susp & wait_mode);
    assign load   = kick | en_rise;

    wdk_counter #(.WTW(WTW)) u_cnt (
        .clk(clk), .por_n(por_n), .srst_n(sys_rst_n),
        .en(ctl.en), .freeze(freeze), .tick(tick), .load(load),
        .wt(ctl_nxt.wt), .toe(ctl.toe),
        .expire_o(expire), .rst_req_o(rst_req), .wdt_out_o(wdt_out)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTL: begin
                bus_rdata[B_LP]          = ctl.lp_susp;
                bus_rdata[B_DBG]         = ctl.dbg_susp;
                bus_rdata[B_EN]          = ctl.en;
                bus_rdata[B_TOE]         = ctl.toe;
                bus_rdata[B_WAIT]        = ctl.wait_susp;
                bus_rdata[B_WT +: WT_W]  = ctl.wt;
            end
            SEL_STAT: bus_rdata[1:0] = stat;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/wdk_top_test.sv
`timescale 1ns/1ps
module wdk_top_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick = 1'b0, dbg_mode = 1'b0, lp_mode = 1'b0, wait_mode = 1'b0;
    logic        rst_req, wdt_out;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdk_top uut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .dbg_mode(dbg_mode), .lp_mode(lp_mode), .wait_mode(wait_mode),
        .rst_req(rst_req), .wdt_out(wdt_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic sreset();
        sys_rst_n = 1'b0;
        @(negedge clk);
        sys_rst_n = 1'b1;
        @(negedge clk);
    endtask

    // n ticks; a pulse is expected only on tick number exp_at (0 = never)
    task automatic run_ticks(input int n, input int exp_at, input string tag);
        for (int i = 1; i <= n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            chk(tag, {15'd0, rst_req}, {15'd0, (i == exp_at)});
            if (i == exp_at) begin
                @(negedge clk);
                chk("R6 pulse width", {15'd0, rst_req}, 16'd0);
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        logic [15:0] v;
        int wts[11] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 255};
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        sys_rst_n = 1'b1;
        @(negedge clk);

        rd(3'd4, v); chk("R9 status after power-on", v, 16'h0001);
        rd(3'd0, v); chk("R1 control reset value", v, 16'h0000);
        chk("R7 wdt_out at reset", {15'd0, wdt_out}, 16'd0);

        // R10: disabled, ticks ignored
        run_ticks(5, 0, "R10 disabled no request");

        // R1 map
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); chk("R1 control writable bits", v, 16'hFF8F);
        rd(3'd2, v); chk("R1 service reads 0", v, 16'h0000);
        rd(3'd6, v); chk("R1 unused slot reads 0", v, 16'h0000);
        // R2 sticky enable
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R2 enable sticky", v, 16'h0004);
        // R9 read-only
        wr(3'd4, 16'hFFFF);
        rd(3'd4, v); chk("R9 status read-only", v, 16'h0001);
        sreset();
        rd(3'd4, v); chk("R9 status no timeout", v, 16'h0001);
        rd(3'd0, v); chk("R2 enable cleared by reset", v, 16'h0000);

        // Sweep of timeout field: R3, R11, R6, R7, R4, R9
        foreach (wts[k]) begin
            int w = wts[k];
            logic toe = w[0];
            sreset();
            wr(3'd0, 16'(w << 8) | 16'h0004 | (toe ? 16'h0008 : 16'h0000));
            run_ticks(w + 1, w + 1, "R11/R3 expiry after enable");
            chk("R7 wdt_out follows bit3", {15'd0, wdt_out}, {15'd0, toe});
            run_ticks(w + 1, w + 1, "R6 re-expiry after reload");
            wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
            run_ticks(w + 1, w + 1, "R4/R3 expiry after service");
            sreset();
            rd(3'd4, v); chk("R9 status after timeout", v, 16'h0002);
            chk("R7 wdt_out cleared by reset", {15'd0, wdt_out}, 16'd0);
        end

        // R5 / R4 key sequence
        sreset();
        wr(3'd0, 16'h0304);                 // WT=3, 4 periods
        run_ticks(2, 0, "R5 pre");
        wr(3'd2, 16'hAAAA);                 // lone fire key
        run_ticks(2, 2, "R5 lone AAAA no reload");
        run_ticks(2, 0, "R5 pre2");
        wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
        run_ticks(2, 2, "R5 disarmed by other value");
        run_ticks(2, 0, "R4 pre");
        wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
        run_ticks(4, 4, "R4 ordered pair reloads");

        // R8 freeze
        sreset();
        wr(3'd0, 16'h0206);                 // WT=2, dbg suspend, enable
        dbg_mode = 1'b1;
        run_ticks(6, 0, "R8 frozen in debug");
        dbg_mode = 1'b0;
        run_ticks(3, 3, "R8 resumes after debug");
        wr(3'd0, 16'h0284);                 // WT=2, wait suspend
        wait_mode = 1'b1;
        run_ticks(6, 0, "R8 frozen in wait");
        wait_mode = 1'b0; lp_mode = 1'b1;   // lp suspend bit clear
        run_ticks(3, 3, "R8 lp mode without suspend bit");
        lp_mode = 1'b0;
        wr(3'd0, 16'h0205);                 // lp suspend
        lp_mode = 1'b1;
        run_ticks(6, 0, "R8 frozen in low power");
        lp_mode = 1'b0;
        run_ticks(3, 3, "R8 resumes after low power");

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule